// File: doc/BRIEF.md
# Bit-Test Conditional Branch Unit

This execution block resolves the short relative conditional branches of an 8-bit microcontroller core. Once an instruction has been decoded and its operand fetched, the core presents the operation class, the operand form, the instruction length, a signed 8-bit displacement, the current program counter, the operand byte and a bit index. The block then returns the next program counter, an optional write-back of the operand byte and the instruction's cycle cost.

Four operation classes are handled. Three select one bit of the operand: branch when it is one, branch when it is zero, and branch when it is one while also clearing it. The fourth decrements a count byte and branches while the result is nonzero. The block computes every target the same way: the program counter plus the instruction's own byte length, plus the sign-extended displacement when the branch is taken. Results are registered and appear one clock after the issue strobe.

Top module: `brc_unit`

## Requirements
- R1: While reset is active and until the first issue, `done_o`, `taken_o`, `wb_en_o` and `flags_dirty_o` are 0, and `next_pc_o`, `wb_data_o` and `cycles_o` are 0.
- R2: On a taken branch, `next_pc_o` equals `pc_i + len_i + sext16(disp_i)` modulo 65536, where `disp_i` is two's complement.
- R3: On a branch that is not taken, `next_pc_o` equals `pc_i + len_i` modulo 65536.
- R4: Class 0 (branch on bit one) is taken exactly when `op_i[bit_sel_i]` is 1 and never asserts `wb_en_o`.
- R5: Class 1 (branch on bit zero) is taken exactly when `op_i[bit_sel_i]` is 0 and never asserts `wb_en_o`.
- R6: Class 2 (test and clear) is taken exactly when `op_i[bit_sel_i]` is 1. In that case `wb_en_o` is 1 and `wb_data_o` is `op_i` with that bit forced to 0. When it is not taken, `wb_en_o` is 0.
- R7: Class 3 (decrement) always asserts `wb_en_o` with `wb_data_o = op_i - 1` modulo 256, and it is taken exactly when that result is nonzero. An operand of 0 gives 0xFF and is taken.
- R8: `cycles_o` follows the class, the form (0 short-direct, 1 special-function register, 2 accumulator, 3 status word, 4 indirect, 5 count register B, 6 count register C) and `fast_area_i`, where values are given as fast/slow. Class 0: forms 0 8/9, 1 11, 2 8, 3 9, 4 10/11. Class 1: form 0 10/11, 1 11, 2 8, 3 11, 4 10/11. Class 2: form 0 10/12, 1 12, 2 8, 3 12, 4 10/12. Class 3: forms 5 and 6 give 6, and form 0 gives 8/10.
- R9: `flags_dirty_o` is 1 in the result cycle of class 2 instructions only, whether or not the branch is taken.
- R10: `done_o` is high for exactly one cycle, the one after each issue cycle. Without an issue, `done_o` and `wb_en_o` are 0 and `next_pc_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| issue_i | input | 1 | Strobe: the inputs below hold a valid instruction |
| cls_i | input | 2 | Operation class (0 bit-one, 1 bit-zero, 2 test-and-clear, 3 decrement) |
| form_i | input | 3 | Operand form code, used for the cycle cost |
| fast_area_i | input | 1 | 1 = operand in internal high-speed RAM or no data access |
| len_i | input | 3 | Instruction length in bytes (2 to 4) |
| disp_i | input | 8 | Signed branch displacement |
| pc_i | input | 16 | Program counter of the instruction |
| op_i | input | 8 | Operand byte |
| bit_sel_i | input | 3 | Index of the tested bit |
| done_o | output | 1 | Result valid pulse |
| taken_o | output | 1 | Branch taken |
| next_pc_o | output | 16 | Next program counter |
| wb_en_o | output | 1 | Operand write-back enable |
| wb_data_o | output | 8 | Operand write-back value |
| cycles_o | output | 4 | Instruction cycle cost |
| flags_dirty_o | output | 1 | Flags are modified by this instruction |

## Verification
Every result belongs to the clock edge that follows the issue cycle. The reset release adds two more edges before the first issue is accepted. The bench drives each instruction on a falling edge and holds it across exactly one rising edge. It then samples all outputs on the next falling edge, against values that its own functions compute from the requirements. After some instructions the bench leaves one idle cycle and samples again, to confirm that the valid pulse has dropped and the program counter is held.

// File: rtl/brc_pkg.sv
package brc_pkg;
  typedef enum logic [1:0] {
    CLS_BIT_ONE  = 2'd0,
    CLS_BIT_ZERO = 2'd1,
    CLS_TST_CLR  = 2'd2,
    CLS_DEC      = 2'd3
  } brc_cls_e;

  typedef enum logic [2:0] {
    FRM_SDIR  = 3'd0,
    FRM_SFR   = 3'd1,
    FRM_ACC   = 3'd2,
    FRM_PSW   = 3'd3,
    FRM_IND   = 3'd4,
    FRM_CNT_B = 3'd5,
    FRM_CNT_C = 3'd6
  } brc_form_e;
endpackage

// File: rtl/brc_target.sv
module brc_target #(
  parameter int PC_W   = 16,
  parameter int DISP_W = 8,
  parameter int LEN_W  = 3
) (
  input  logic [PC_W-1:0]   pc_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic              take_i,
  output logic [PC_W-1:0]   next_pc_o
);
  localparam int EXT_W = PC_W - DISP_W;

  logic [PC_W-1:0] seq_pc;
  logic [PC_W-1:0] disp_ext;

  assign disp_ext = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};

  always_comb begin
    seq_pc = pc_i + PC_W'(len_i);
    if (take_i) next_pc_o = seq_pc + disp_ext;
    else        next_pc_o = seq_pc;
  end
endmodule

// File: rtl/brc_cond.sv
module brc_cond
  import brc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BIDX_W = $clog2(DATA_W)
) (
  input  brc_cls_e            cls_i,
  input  logic [DATA_W-1:0]   op_i,
  input  logic [BIDX_W-1:0]   bit_sel_i,
  output logic                take_o,
  output logic                wb_en_o,
  output logic [DATA_W-1:0]   wb_data_o,
  output logic                flags_dirty_o
);
  logic [DATA_W-1:0] op_cleared;
  logic [DATA_W-1:0] op_decr;
  logic              sel_bit;
  logic              decr_nz;

  for (genvar g = 0; g < DATA_W; g++) begin : g_clr
    assign op_cleared[g] = op_i[g] & (bit_sel_i != BIDX_W'(g));
  end

  assign sel_bit = op_i[bit_sel_i];
  assign op_decr = op_i - DATA_W'(1);
  assign decr_nz = |op_decr;

  always_comb begin
    take_o        = 1'b0;
    wb_en_o       = 1'b0;
    wb_data_o     = op_i;
    flags_dirty_o = 1'b0;
    unique case (cls_i)
      CLS_BIT_ONE:  take_o = sel_bit;
      CLS_BIT_ZERO: take_o = ~sel_bit;
      CLS_TST_CLR: begin
        take_o        = sel_bit;
        flags_dirty_o = 1'b1;
        if (sel_bit) begin
          wb_en_o   = 1'b1;
          wb_data_o = op_cleared;
        end
      end
      CLS_DEC: begin
        take_o    = decr_nz;
        wb_en_o   = 1'b1;
        wb_data_o = op_decr;
      end
      default: take_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/brc_cost.sv
module brc_cost
  import brc_pkg::*;
#(
  parameter int CYC_W = 4
) (
  input  brc_cls_e         cls_i,
  input  brc_form_e        form_i,
  input  logic             fast_i,
  output logic [CYC_W-1:0] cycles_o
);
  function automatic logic [CYC_W-1:0] pick(input logic f, input int lo, input int hi);
    return f ? CYC_W'(lo) : CYC_W'(hi);
  endfunction

  always_comb begin
    cycles_o = CYC_W'(8);
    unique case (cls_i)
      CLS_BIT_ONE: begin
        case (form_i)
          FRM_SDIR: cycles_o = pick(fast_i, 8, 9);
          FRM_SFR:  cycles_o = CYC_W'(11);
          FRM_PSW:  cycles_o = CYC_W'(9);
          FRM_IND:  cycles_o = pick(fast_i, 10, 11);
          default:  cycles_o = CYC_W'(8);
        endcase
      end
      CLS_BIT_ZERO: begin
        case (form_i)
          FRM_SDIR: cycles_o = pick(fast_i, 10, 11);
          FRM_SFR:  cycles_o = CYC_W'(11);
          FRM_PSW:  cycles_o = CYC_W'(11);
          FRM_IND:  cycles_o = pick(fast_i, 10, 11);
          default:  cycles_o = CYC_W'(8);
        endcase
      end
      CLS_TST_CLR: begin
        case (form_i)
          FRM_SDIR: cycles_o = pick(fast_i, 10, 12);
          FRM_SFR:  cycles_o = CYC_W'(12);
          FRM_PSW:  cycles_o = CYC_W'(12);
          FRM_IND:  cycles_o = pick(fast_i, 10, 12);
          default:  cycles_o = CYC_W'(8);
        endcase
      end
      CLS_DEC: begin
        case (form_i)
          FRM_CNT_B, FRM_CNT_C: cycles_o = CYC_W'(6);
          default:              cycles_o = pick(fast_i, 8, 10);
        endcase
      end
      default: cycles_o = CYC_W'(8);
    endcase
  end
endmodule

// File: rtl/brc_unit.sv
module brc_unit
  import brc_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int DATA_W = 8,
  parameter int DISP_W = 8,
  parameter int LEN_W  = 3,
  parameter int CYC_W  = 4,
  parameter int BIDX_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic [1:0]        cls_i,
  input  logic [2:0]        form_i,
  input  logic              fast_area_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [DATA_W-1:0] op_i,
  input  logic [BIDX_W-1:0] bit_sel_i,
  output logic              done_o,
  output logic              taken_o,
  output logic [PC_W-1:0]   next_pc_o,
  output logic              wb_en_o,
  output logic [DATA_W-1:0] wb_data_o,
  output logic [CYC_W-1:0]  cycles_o,
  output logic              flags_dirty_o
);
  localparam int SYNC_D = 2;

  logic [SYNC_D-1:0] rst_pipe;
  logic              rst_n_sync;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe <= '0;
    else         rst_pipe <= {rst_pipe[SYNC_D-2:0], 1'b1};
  end
  assign rst_n_sync = rst_pipe[SYNC_D-1];

  brc_cls_e          cls;
  brc_form_e         form;
  logic              take_c;
  logic              wb_en_c;
  logic [DATA_W-1:0] wb_data_c;
  logic              flags_c;
  logic [PC_W-1:0]   pc_c;
  logic [CYC_W-1:0]  cyc_c;

  assign cls  = brc_cls_e'(cls_i);
  assign form = brc_form_e'(form_i);

  brc_cond #(.DATA_W(DATA_W), .BIDX_W(BIDX_W)) u_cond (
    .cls_i         (cls),
    .op_i          (op_i),
    .bit_sel_i     (bit_sel_i),
    .take_o        (take_c),
    .wb_en_o       (wb_en_c),
    .wb_data_o     (wb_data_c),
    .flags_dirty_o (flags_c)
  );

  brc_target #(.PC_W(PC_W), .DISP_W(DISP_W), .LEN_W(LEN_W)) u_target (
    .pc_i      (pc_i),
    .len_i     (len_i),
    .disp_i    (disp_i),
    .take_i    (take_c),
    .next_pc_o (pc_c)
  );

  brc_cost #(.CYC_W(CYC_W)) u_cost (
    .cls_i    (cls),
    .form_i   (form),
    .fast_i   (fast_area_i),
    .cycles_o (cyc_c)
  );

  logic              done_d, taken_d, wb_en_d, flags_d;
  logic [PC_W-1:0]   pc_d;
  logic [DATA_W-1:0] wbd_d;
  logic [CYC_W-1:0]  cyc_d;

  always_comb begin
    done_d  = issue_i;
    wb_en_d = issue_i & wb_en_c;
    flags_d = issue_i & flags_c;
    taken_d = taken_o;
    pc_d    = next_pc_o;
    wbd_d   = wb_data_o;
    cyc_d   = cycles_o;
    if (issue_i) begin
      taken_d = take_c;
      pc_d    = pc_c;
      wbd_d   = wb_data_c;
      cyc_d   = cyc_c;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      done_o        <= 1'b0;
      taken_o       <= 1'b0;
      next_pc_o     <= '0;
      wb_en_o       <= 1'b0;
      wb_data_o     <= '0;
      cycles_o      <= '0;
      flags_dirty_o <= 1'b0;
    end else begin
      done_o        <= done_d;
      taken_o       <= taken_d;
      next_pc_o     <= pc_d;
      wb_en_o       <= wb_en_d;
      wb_data_o     <= wbd_d;
      cycles_o      <= cyc_d;
      flags_dirty_o <= flags_d;
    end
  end
endmodule

// File: rtl/brc_unit_chk.sv
module brc_unit_chk #(
  parameter int PC_W   = 16,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_n,
  input logic              issue_i,
  input logic [1:0]        cls_i,
  input logic [DATA_W-1:0] op_i,
  input logic              done_o,
  input logic              taken_o,
  input logic              wb_en_o,
  input logic [DATA_W-1:0] wb_data_o,
  input logic              flags_dirty_o,
  input logic [PC_W-1:0]   next_pc_o
);
  AST_DONE_AFTER_ISSUE: assert property (@(posedge clk_i) disable iff (!rst_n)
    done_o == $past(issue_i)) else $error("done pulse misplaced"); // R10

  AST_PC_HELD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_n)
    !$past(issue_i) |-> $stable(next_pc_o)) else $error("pc moved while idle"); // R10

  AST_BIT_FORMS_NO_WB: assert property (@(posedge clk_i) disable iff (!rst_n)
    (done_o && $past(cls_i) < 2'd2) |-> !wb_en_o) else $error("bit branch wrote back"); // R4

  AST_TSTCLR_WB_IFF_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_n)
    (done_o && $past(cls_i) == 2'd2) |-> (wb_en_o == taken_o)) else $error("test-clear write mismatch"); // R6

  AST_DEC_WRITES_COUNT: assert property (@(posedge clk_i) disable iff (!rst_n)
    (done_o && $past(cls_i) == 2'd3) |-> (wb_en_o && wb_data_o == ($past(op_i) - DATA_W'(1))))
    else $error("decrement write wrong"); // R7

  AST_FLAGS_ONLY_TSTCLR: assert property (@(posedge clk_i) disable iff (!rst_n)
    flags_dirty_o |-> (done_o && $past(cls_i) == 2'd2)) else $error("flags marked wrongly"); // R9
endmodule

bind brc_unit brc_unit_chk #(.PC_W(PC_W), .DATA_W(DATA_W)) u_chk (
  .clk_i         (clk_i),
  .rst_n         (rst_n_sync),
  .issue_i       (issue_i),
  .cls_i         (cls_i),
  .op_i          (op_i),
  .done_o        (done_o),
  .taken_o       (taken_o),
  .wb_en_o       (wb_en_o),
  .wb_data_o     (wb_data_o),
  .flags_dirty_o (flags_dirty_o),
  .next_pc_o     (next_pc_o)
);

// File: tb/sim_brc_unit.sv
`timescale 1ns/1ps
module sim_brc_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue;
  logic [1:0]  cls;
  logic [2:0]  form;
  logic        fast;
  logic [2:0]  len;
  logic [7:0]  disp;
  logic [15:0] pc;
  logic [7:0]  op;
  logic [2:0]  bsel;
  logic        done, taken, wb_en, flags;
  logic [15:0] npc;
  logic [7:0]  wbd;
  logic [3:0]  cyc;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  brc_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .issue_i(issue), .cls_i(cls), .form_i(form),
    .fast_area_i(fast), .len_i(len), .disp_i(disp), .pc_i(pc), .op_i(op),
    .bit_sel_i(bsel), .done_o(done), .taken_o(taken), .next_pc_o(npc),
    .wb_en_o(wb_en), .wb_data_o(wbd), .cycles_o(cyc), .flags_dirty_o(flags)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int ref_len(input int c, input int f);
    if (c == 3) return (f == 0) ? 3 : 2;
    case (f)
      0: return (c == 0) ? 3 : 4;
      1: return 4;
      3: return (c == 0) ? 3 : 4;
      default: return 3;
    endcase
  endfunction

  function automatic int ref_cyc(input int c, input int f, input bit fa);
    if (c == 3) return (f == 0) ? (fa ? 8 : 10) : 6;
    case (f)
      0: return (c == 0) ? (fa ? 8 : 9) : (c == 1) ? (fa ? 10 : 11) : (fa ? 10 : 12);
      1: return (c == 2) ? 12 : 11;
      2: return 8;
      3: return (c == 0) ? 9 : (c == 1) ? 11 : 12;
      default: return fa ? 10 : ((c == 2) ? 12 : 11);
    endcase
  endfunction

  task automatic run(input int c, input int f, input bit fa, input int d, input int p,
                     input int o, input int b, input bit idle_after);
    bit         sb, tk, we;
    logic [7:0] wv;
    logic [15:0] exp_pc;
    int          ln;
    @(negedge clk);
    ln = ref_len(c, f);
    issue = 1'b1; cls = 2'(c); form = 3'(f); fast = fa; len = 3'(ln);
    disp = 8'(d); pc = 16'(p); op = 8'(o); bsel = 3'(b);
    sb = op[bsel];
    we = 1'b0; wv = op;
    case (c)
      0: tk = sb;
      1: tk = !sb;
      2: begin tk = sb; we = sb; if (sb) wv = op & ~(8'd1 << bsel); end
      default: begin wv = op - 8'd1; we = 1'b1; tk = (wv != 0); end
    endcase
    exp_pc = pc + 16'(ln) + (tk ? {{8{disp[7]}}, disp} : 16'd0);
    @(negedge clk);
    issue = 1'b0;
    check("R10", "done", int'(done), 1);
    check(tk ? "R2" : "R3", "next_pc", int'(npc), int'(exp_pc));
    case (c)
      0: check("R4", "taken", int'(taken), int'(tk));
      1: check("R5", "taken", int'(taken), int'(tk));
      2: check("R6", "taken", int'(taken), int'(tk));
      default: check("R7", "taken", int'(taken), int'(tk));
    endcase
    if (c < 2) check(c == 0 ? "R4" : "R5", "wb_en", int'(wb_en), 0);
    else begin
      check(c == 2 ? "R6" : "R7", "wb_en", int'(wb_en), int'(we));
      if (we) check(c == 2 ? "R6" : "R7", "wb_data", int'(wbd), int'(wv));
    end
    check("R8", "cycles", int'(cyc), ref_cyc(c, f, fa));
    check("R9", "flags_dirty", int'(flags), int'(c == 2));
    if (idle_after) begin
      @(negedge clk);
      check("R10", "idle done", int'(done), 0);
      check("R10", "idle wb_en", int'(wb_en), 0);
      check("R10", "idle pc hold", int'(npc), int'(exp_pc));
    end
  endtask

  function automatic int rnd_form(input int c);
    int k;
    if (c == 3) begin
      k = int'($urandom_range(0, 2));
      return (k == 0) ? 0 : k + 4;
    end
    return int'($urandom_range(0, 4));
  endfunction

  task automatic report;
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    void'($urandom(32'h1bad5eed));
    rst_n = 1'b0; issue = 1'b0; cls = '0; form = '0; fast = 1'b0; len = '0;
    disp = '0; pc = '0; op = '0; bsel = '0;
    repeat (3) @(negedge clk);
    check("R1", "reset done", int'(done), 0);
    check("R1", "reset pc", int'(npc), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "idle done", int'(done), 0);
    check("R1", "idle wb_en", int'(wb_en), 0);
    check("R1", "idle flags", int'(flags), 0);
    check("R1", "idle taken", int'(taken), 0);
    check("R1", "idle cycles", int'(cyc), 0);
    check("R1", "idle wb_data", int'(wbd), 0);
    // directed corners
    run(0, 0, 1, 8'h05, 16'hFFFE, 8'h80, 7, 1);  // R2 wrap forward
    run(1, 2, 0, 8'h80, 16'h0010, 8'hFE, 0, 1);  // R5 taken, -128, wrap back
    run(0, 4, 0, 8'h10, 16'h1234, 8'h00, 3, 0);  // R3 not taken
    run(2, 0, 1, 8'h7F, 16'h2000, 8'hFF, 7, 1);  // R6 clears bit 7
    run(2, 3, 0, 8'h22, 16'h3000, 8'hFE, 0, 1);  // R6 not taken, no write
    run(3, 5, 1, 8'hF0, 16'h4000, 8'h00, 0, 1);  // R7 0 -> FF taken
    run(3, 6, 0, 8'h33, 16'h5000, 8'h01, 0, 1);  // R7 1 -> 0 not taken
    run(3, 0, 0, 8'h01, 16'hFFFF, 8'h80, 0, 0);  // R7 saddr form
    for (int cc = 0; cc < 3; cc++)
      for (int ff = 0; ff < 5; ff++)
        for (int aa = 0; aa < 2; aa++)
          run(cc, ff, aa[0], 8'h02, 16'h0100, 8'h5A, ff, 0);  // R8 table sweep
    for (int i = 0; i < 400; i++) begin
      int c;
      c = int'($urandom_range(0, 3));
      run(c, rnd_form(c), 1'($urandom), int'($urandom_range(0, 255)),
          int'($urandom_range(0, 65535)), int'($urandom_range(0, 255)),
          int'($urandom_range(0, 7)), (i % 7) == 0);
    end
    repeat (2) @(negedge clk);
    report();
  end
endmodule